// File: doc/BRIEF.md
# Word-Serial Systolic Montgomery Multiplier

This block forms the Montgomery product `A = x * y * R^-1 mod m`, where `R = b^N` and the digit base is `b = 2^K`. Every operand is split into `N` words of `K` bits. Word `j` occupies bits `[j*K+K-1 : j*K]`, so word 0 is the least significant. A chain of `N` word cells holds one word of `y` and one word of `m` each. A quotient unit derives one reduction digit per outer round. A controller scans the words of `x` from the least significant upward.

Each round takes two clock cycles. In the first cycle the quotient digit is registered. In the second cycle every cell adds its share of `x_i*y + u_i*m` and keeps the upper part of its sum as a local carry. The lower part is handed one cell down, which performs the division by `b`. After `N` rounds the value exists in a redundant form of words plus carries. A word-serial pass of `N` cycles folds it into the plain result.

The conditional final subtraction is left out. When `x < 2m`, `y < 2m`, `m` is odd and `4m < b^N`, the result is already below `2m` and can feed the next product directly. Entering and leaving the Montgomery domain are handled outside the block.

The operand side is an input stream. `in_valid` offers one operand set, and `in_ready` is high only while the block is idle. A set is taken on a clock edge where both are high. An offer made while the block is busy is not taken and stays pending until `in_ready` rises. The output side has no back-pressure: `done` pulses for one cycle, and `result` holds its value until the next set is taken.

Top module: `mont_mul_systolic`

## Requirements
- R1: While reset is asserted, and right after it is released, `in_ready` is 1, `done` is 0 and `result` is 0.
- R2: An operand set is taken on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle through the `done` cycle, and returns to 1 in the cycle after `done`.
- R3: When `done` is 1, `result` is congruent to `x*y*b^-N` modulo `m`. Here `mprime_in` must equal `(-m^-1) mod 2^K`, and in every reduction round the low word of the cell sums is zero.
- R4: For odd `m` with `x < 2m`, `y < 2m` and `4m < b^N`, the `result` is below `2m`.
- R5: `done` is high for exactly one cycle, on the 3N-th clock edge after the edge that took the operands.
- R6: An `in_valid` offer, or a change on the operand inputs, while `in_ready` is 0 has no effect on the running product or on its result.
- R7: `result` does not change from the `done` cycle until the next operand set is taken.
- R8: If `x` or `y` is zero, the `result` is exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand set is offered |
| in_ready | output | 1 | Block is idle and will take an offered set |
| x_in | input | K*N | Multiplier operand x |
| y_in | input | K*N | Multiplicand operand y |
| m_in | input | K*N | Odd modulus m |
| mprime_in | input | K | Constant (-m^-1) mod 2^K |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | K*N | Montgomery product, below 2m |

## Verification
Two events can meet in the same cycle: the block finishing a product (`done`) and a new operand offer on `in_valid`. The bench raises a second offer while the first product is still running and keeps it asserted through the `done` cycle. It then checks three things: the first result belongs to the first operands, the offer is taken only on the edge after `done` and not during it, and the second result is correct and arrives with the same latency. A small configuration (K=4, N=3) is swept over several odd moduli, with each operand running across its full range [0, 2m) including both ends. Every result is judged arithmetically for congruence modulo `m`, for the bound below `2m`, and for its latency.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUOT,
    ST_STEP,
    ST_FOLD,
    ST_FIN
  } mm_state_e;
endpackage

// File: rtl/mm_quot.sv
// Quotient digit unit: u = (a0 + c0 + xw*y0) * mp mod 2^K, registered.
module mm_quot #(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [K-1:0] a0,
  input  logic [K-1:0] c0,
  input  logic [K-1:0] xw,
  input  logic [K-1:0] y0,
  input  logic [K-1:0] mp,
  output logic [K-1:0] u_q
);
  logic [K-1:0] t_low;
  logic [K-1:0] u_nx;

  always_comb begin
    t_low = a0 + c0 + xw * y0;
    u_nx  = t_low * mp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  u_q <= '0;
    else if (en) u_q <= u_nx;
  end
endmodule

// File: rtl/mm_cell.sv
// One word cell of the systolic chain. It keeps its word of y and m,
// a partial word and a local carry. The top cell receives no word from above.
module mm_cell #(
  parameter int K   = 16,
  parameter bit TOP = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [K-1:0] y_in,
  input  logic [K-1:0] m_in,
  input  logic [K-1:0] xw,
  input  logic [K-1:0] u,
  input  logic [K-1:0] from_up,
  output logic [K-1:0] to_down,
  output logic [K-1:0] acc_w,
  output logic [K:0]   car_w
);
  localparam int SW = 2 * K + 1;

  logic [K-1:0] y_q, m_q, acc_q;
  logic [K:0]   car_q;
  logic [K-1:0] next_acc;
  logic [SW-1:0] sum;

  generate
    if (TOP) begin : g_top
      assign next_acc = '0;
    end else begin : g_mid
      assign next_acc = from_up;
    end
  endgenerate

  always_comb begin
    sum = SW'(acc_q) + SW'(car_q) + SW'(xw) * SW'(y_q) + SW'(u) * SW'(m_q);
  end

  assign to_down = sum[K-1:0];
  assign acc_w   = acc_q;
  assign car_w   = car_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= '0;
      m_q   <= '0;
      acc_q <= '0;
      car_q <= '0;
    end else if (load) begin
      y_q   <= y_in;
      m_q   <= m_in;
      acc_q <= '0;
      car_q <= '0;
    end else if (step) begin
      acc_q <= next_acc;
      car_q <= sum[SW-1:K];
    end
  end
endmodule

// File: rtl/mm_ctrl.sv
// Word-scanning sequencer: N rounds of (quotient, step), then N fold cycles.
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          load,
  output logic          quot_en,
  output logic          step_en,
  output logic          fold_en,
  output logic          done,
  output logic [IW-1:0] idx
);
  mm_state_e state;
  logic      last_idx;

  always_comb begin
    in_ready = (state == ST_IDLE);
    load     = in_ready && in_valid;
    quot_en  = (state == ST_QUOT);
    step_en  = (state == ST_STEP);
    fold_en  = (state == ST_FOLD);
    done     = (state == ST_FIN);
    last_idx = (idx == IW'(N - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_QUOT;
          idx   <= '0;
        end
        ST_QUOT: state <= ST_STEP;
        ST_STEP: begin
          if (last_idx) begin
            idx   <= '0;
            state <= ST_FOLD;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_QUOT;
          end
        end
        ST_FOLD: begin
          if (last_idx) begin
            idx   <= '0;
            state <= ST_FIN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_mul_systolic.sv
module mont_mul_systolic #(
  parameter int K = 16,
  parameter int N = 4,
  localparam int W  = K * N,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] m_in,
  input  logic [K-1:0] mprime_in,
  output logic         done,
  output logic [W-1:0] result
);
  logic          load, quot_en, step_en, fold_en;
  logic [IW-1:0] idx;

  logic [K-1:0] x_q [N];
  logic [K-1:0] res_q [N];
  logic [W-1:0] m_q;
  logic [K-1:0] mp_q;
  logic [1:0]   rc_q;
  logic [K-1:0] u_q;
  logic [K-1:0] xw;

  logic [K-1:0] acc_w [N];
  logic [K:0]   car_w [N];
  logic [K-1:0] dn_w  [N+1];
  logic [K-1:0] pe0_low;
  logic [K+1:0] fsum;

  mm_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .quot_en(quot_en), .step_en(step_en), .fold_en(fold_en),
    .done(done), .idx(idx)
  );

  assign xw = x_q[idx];

  mm_quot #(.K(K)) u_quot (
    .clk(clk), .rst_n(rst_n), .en(quot_en),
    .a0(acc_w[0]), .c0(car_w[0][K-1:0]), .xw(xw), .y0(y_in_w0_q), .mp(mp_q),
    .u_q(u_q)
  );

  // Word 0 of y is kept here as well, so the quotient unit reads a register.
  logic [K-1:0] y_in_w0_q;

  assign dn_w[N]  = '0;
  assign pe0_low  = dn_w[0];

  genvar j;
  generate
    for (j = 0; j < N; j++) begin : g_cell
      mm_cell #(.K(K), .TOP(j == N - 1)) u_cell (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step_en),
        .y_in(y_in[j*K +: K]), .m_in(m_in[j*K +: K]),
        .xw(xw), .u(u_q), .from_up(dn_w[j+1]), .to_down(dn_w[j]),
        .acc_w(acc_w[j]), .car_w(car_w[j])
      );
      assign result[j*K +: K] = res_q[j];
    end
  endgenerate

  always_comb begin
    fsum = (K+2)'(acc_w[idx]) + (K+2)'(car_w[idx]) + (K+2)'(rc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < N; w++) begin
        x_q[w]   <= '0;
        res_q[w] <= '0;
      end
      m_q       <= '0;
      mp_q      <= '0;
      rc_q      <= '0;
      y_in_w0_q <= '0;
    end else if (load) begin
      for (int w = 0; w < N; w++) x_q[w] <= x_in[w*K +: K];
      m_q       <= m_in;
      mp_q      <= mprime_in;
      rc_q      <= '0;
      y_in_w0_q <= y_in[K-1:0];
    end else if (fold_en) begin
      res_q[idx] <= fsum[K-1:0];
      rc_q       <= fsum[K+1:K];
    end
  end
endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
  parameter int K = 16,
  parameter int N = 4,
  localparam int W  = K * N,
  localparam int CW = $clog2(3 * N + 1) + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic         step_en,
  input logic [K-1:0] low0,
  input logic [W-1:0] result,
  input logic [W-1:0] mod_q
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (in_valid && in_ready) cnt <= '0;
    else if (!in_ready && cnt != '1) cnt <= cnt + 1'b1;
  end

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_not_ready_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  assert_low_word_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (low0 == '0));

  assert_below_twice_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, result} < {mod_q, 1'b0}));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == CW'(3 * N)));

  assert_busy_ignores_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(mod_q));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && $past(in_ready)) |-> $stable(result));

  assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> $stable(result));
endmodule

bind mont_mul_systolic mm_chk #(.K(K), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .step_en(step_en), .low0(pe0_low), .result(result), .mod_q(m_q)
);

// File: tb/tb_mont_mul_systolic.sv
module tb_mont_mul_systolic;
  localparam int K = 4;
  localparam int N = 3;
  localparam int W = K * N;
  localparam int CLK_PERIOD = 10;
  localparam longint RV = 64'd1 << W;
  localparam int EXP_LAT = 3 * N + 1;  // falling edges after the taking edge

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] x_in = '0, y_in = '0, m_in = '0;
  logic [K-1:0] mprime_in = '0;
  logic         in_ready, done;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mont_mul_systolic #(.K(K), .N(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x_in(x_in), .y_in(y_in), .m_in(m_in), .mprime_in(mprime_in),
    .done(done), .result(result)
  );

  function automatic logic [K-1:0] mp_of(longint m);
    for (int u = 0; u < (1 << K); u++)
      if (((m * u + 1) % (1 << K)) == 0) return K'(u);
    return '0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(longint x, longint y, longint m);
    x_in = W'(x);
    y_in = W'(y);
    m_in = W'(m);
    mprime_in = mp_of(m);
  endtask

  // Called at the first falling edge after the taking edge.
  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic judge(longint x, longint y, longint m, int lat);
    longint r;
    r = longint'(result);
    check(lat == EXP_LAT, "R5 latency", lat, EXP_LAT);
    check(((r * RV) % m) == ((x * y) % m), "R3 congruence", (r * RV) % m, (x * y) % m);
    check(r < 2 * m, "R4 range", r, 2 * m - 1);
    if (x == 0 || y == 0) check(r == 0, "R8 zero operand", r, 0);
  endtask

  task automatic run(longint x, longint y, longint m);
    int lat;
    @(negedge clk);
    drive(x, y, m);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 busy after take", in_ready, 0);
    wait_done(lat);
    judge(x, y, m, lat);
    @(negedge clk);
    check(done == 1'b0, "R5 single pulse", done, 0);
    check(in_ready == 1'b1, "R2 ready after done", in_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint mods [6] = '{3, 5, 17, 255, 683, 1023};
    logic [W-1:0] held;
    int lat;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(result == '0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0 && result == '0, "R1 after release",
          {in_ready, done, (result == '0)}, 3'b101);

    // Sweep: R3 R4 R5 R8 over operands in [0, 2m)
    foreach (mods[mi]) begin
      longint m, top;
      m = mods[mi];
      top = 2 * m - 1;
      for (int a = 0; a < 20; a++) begin
        for (int b = 0; b < 20; b++) begin
          run((top * a) / 19, (top * b) / 19, m);
        end
      end
    end

    // R7: result holds while operand pins change with no offer
    run(700, 1201, 683);
    held = result;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      drive(c * 37, c * 91 + 5, 1023);
      check(result == held, "R7 hold after done", result, held);
    end

    // R6 and R2: offer while busy, held through the done cycle
    @(negedge clk);
    drive(1000, 777, 683);
    in_valid = 1'b1;
    @(negedge clk);
    drive(55, 1300, 683);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R6 offer while busy", in_ready, 0);
    end
    lat = 4;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    judge(1000, 777, 683, lat);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready after done with offer pending", in_ready, 1);
    held = result;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 pending offer taken", in_ready, 0);
    check(result == held, "R7 hold until take", result, held);
    wait_done(lat);
    judge(55, 1300, 683, lat);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule